// File: doc/BRIEF.md
# Single-to-Half Precision Narrowing Converter

This unit turns a 32-bit single-precision operand into a 16-bit half-precision value in one registered stage. Before narrowing, the sign of the source can be altered by two modifiers: one forces the magnitude (absolute value) and one flips the sign. When both are set the operand becomes -|x|. The narrowed value is rounded in one of four modes picked by a two-bit field. Results smaller than the smallest half normal are either kept as true denormals or replaced by a signed zero, depending on a run-time flush input. An optional clamp then limits the result to the closed range from 0.0 to 1.0.

Any finite result whose rounded magnitude is larger than the largest finite half value (65504) becomes infinity with the operand's sign. This holds in every rounding mode, so directed-down rounding of a large positive value still gives +infinity. The block is fed one operand per cycle, with a valid strobe, and shows the result one clock later.

Top module: `f2h_cvt`

## Requirements
- R1: out_valid equals in_valid of the previous clock. When in_valid is low, result keeps its previous value.
- R2: During reset (rst_n low), out_valid is 0 and result is 16'h0000.
- R3: The effective sign is neg_en when abs_en is 1, and the source sign XOR neg_en otherwise. Exponent and fraction are unchanged, so abs and neg together give -|x|.
- R4: rnd_mode selects the rounding: 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero. Normal results are the correctly rounded half value. Half encoding is {sign[15], exponent[14:10] bias 15, fraction[9:0]}.
- R5: If the magnitude rounded per rnd_mode exceeds 65504, or the source exponent field is 143 to 254, the result is {sign, 15'h7C00} in every mode. Examples: 65520 in mode 0 gives 7C00; 65520 in mode 3 gives 7BFF.
- R6: With flush_en low, results below 2^-14 are produced as denormals (exponent field 0), rounded per rnd_mode. Rounding up to 2^-14 gives 16'h0400.
- R7: With flush_en high, any result whose exponent field is 0 and fraction nonzero is replaced by a zero of the same sign.
- R8: A single-precision denormal source (exponent field 0, fraction nonzero) converts as a nonzero value below half the smallest half denormal. Mode 1 gives +2^-24 (16'h0001) for a positive source, mode 2 gives 16'h8001 for a negative one, and the other cases give signed zero (all subject to R7).
- R9: A source infinity gives {sign, 15'h7C00}. A source NaN gives {sign, 5'h1F, 1'b1, src[21:13]}.
- R10: With clamp_en high, NaN and negative results (including -0.0) become 16'h0000. Results above 1.0 (including +infinity) become 16'h3C00. Others pass unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| src | input | 32 | Single-precision operand |
| abs_en | input | 1 | Force the source magnitude before conversion |
| neg_en | input | 1 | Flip the source sign (after abs) |
| rnd_mode | input | 2 | Rounding mode, encoding per R4 |
| flush_en | input | 1 | Replace denormal results by signed zero |
| clamp_en | input | 1 | Limit result to [0.0, 1.0] |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 16 | Half-precision result |

## Verification
The hardest situations to reach from the ports are the rounding carries. These are where a guard bit pushes the fraction over into the next exponent, into the smallest normal, or past 65504. They occur only for a handful of fraction patterns at particular exponents. The stimulus therefore sweeps every source exponent from 95 to 145, plus the special ones. At each exponent it combines fraction heads that are all-zero, one, half and all-one with fraction tails sitting just below, on and just above the halfway point. Every combination runs in all four modes, with flush on and off, at both signs. Randomised operands with random modifiers and clamp are then compared against an exact fixed-point model.

// File: rtl/f2h_pkg.sv
// f2h_pkg: format constants and the rounding-mode type shared by the
// narrowing converter. Assumes IEEE single and half binary layouts.
package f2h_pkg;
    localparam int F32_W    = 32;
    localparam int F32_EW   = 8;
    localparam int F32_MW   = 23;
    localparam int F16_W    = 16;
    localparam int F16_EW   = 5;
    localparam int F16_MW   = 10;
    localparam int MAG_W    = F16_W - 1;
    localparam int SIG_W    = F32_MW + 1;
    localparam int DROP     = F32_MW - F16_MW;           // 13 fraction bits lost when normal
    localparam int BIAS32   = 127;
    localparam int BIAS16   = 15;
    localparam int EXP_NORM = BIAS32 - BIAS16 + 1;       // 113: first half-normal exponent
    localparam int EXP_OVF  = EXP_NORM + 30;             // 143: magnitude >= 2^16
    localparam int SH_MAX   = DROP + 14;                 // 27: shift beyond which only sticky remains
    localparam logic [MAG_W-1:0] H_INF_MAG = 15'h7C00;
    localparam logic [MAG_W-1:0] H_MINNORM = 15'h0400;
    localparam logic [MAG_W-1:0] H_ONE_MAG = 15'h3C00;

    typedef enum logic [1:0] {
        RND_NEAR_EVEN = 2'd0,
        RND_POS_INF   = 2'd1,
        RND_NEG_INF   = 2'd2,
        RND_ZERO      = 2'd3
    } rnd_mode_e;
endpackage

// File: rtl/f2h_srcmod.sv
// f2h_srcmod: applies the abs and negate source modifiers by rewriting the
// sign bit only. Assumes abs is applied before negate, so both give -|x|.
module f2h_srcmod
    import f2h_pkg::*;
(
    input  logic [F32_W-1:0] src,
    input  logic             abs_en,
    input  logic             neg_en,
    output logic [F32_W-1:0] mod_src
);
    logic new_sign;

    // Pick the modified sign: forced by abs, then flipped by neg.
    always_comb begin
        new_sign = abs_en ? neg_en : (src[F32_W-1] ^ neg_en);
        mod_src  = {new_sign, src[F32_W-2:0]};
    end
endmodule

// File: rtl/f2h_narrow.sv
// f2h_narrow: combinational single-to-half narrowing with selectable rounding
// and optional denormal flush. One alignment shifter serves both the normal
// and denormal ranges; a single-precision denormal enters as sticky only.
// Assumes the sign has already been modified.
module f2h_narrow
    import f2h_pkg::*;
(
    input  logic [F32_W-1:0] x,
    input  rnd_mode_e        mode,
    input  logic             flush_en,
    output logic [F16_W-1:0] h
);
    localparam int LOW_W  = SH_MAX - 1;
    localparam int WIDE_W = SIG_W + LOW_W;
    localparam int SUM_W  = MAG_W + 2;

    logic                  s;
    logic [F32_EW-1:0]     e;
    logic [F32_MW-1:0]     m;
    logic [SIG_W-1:0]      sig;
    logic [F32_EW-1:0]     sh_raw;
    logic [4:0]            sh;
    logic [WIDE_W-1:0]     wide;
    logic [SIG_W-1:0]      q_full;
    logic [F16_MW+1:0]     q;
    logic [F16_MW+1:0]     qr;
    logic                  g, st, inc;
    logic [SUM_W-1:0]      base, mag;
    logic [MAG_W-1:0]      mag_o;

    // Align the significand to half-precision units and split off guard/sticky.
    always_comb begin
        s      = x[F32_W-1];
        e      = x[F32_W-2:F32_MW];
        m      = x[F32_MW-1:0];
        sig    = {1'b1, m};
        sh_raw = 8'(EXP_NORM + DROP) - e;
        if (e >= 8'(EXP_NORM))
            sh = 5'(DROP);
        else if (sh_raw > 8'(SH_MAX))
            sh = 5'(SH_MAX);
        else
            sh = sh_raw[4:0];
        wide   = {sig, {LOW_W{1'b0}}} >> sh;
        q_full = wide[WIDE_W-1:LOW_W];
        if (e == '0) begin
            q  = '0;
            g  = 1'b0;
            st = |m;
        end else begin
            q  = 12'(q_full);
            g  = wide[LOW_W-1];
            st = |wide[LOW_W-2:0];
        end
    end

    // Decide the rounding increment from the mode and the sign.
    always_comb begin
        unique case (mode)
            RND_NEAR_EVEN: inc = g & (st | q[0]);
            RND_POS_INF:   inc = ~s & (g | st);
            RND_NEG_INF:   inc = s & (g | st);
            default:       inc = 1'b0;
        endcase
    end

    // Form the magnitude, then apply overflow, flush and special operands.
    always_comb begin
        qr   = q + 12'(inc);
        base = (e >= 8'(EXP_NORM)) ? SUM_W'({e - 8'(EXP_NORM), {F16_MW{1'b0}}}) : '0;
        mag  = base + SUM_W'(qr);
        if (e >= 8'(EXP_OVF) || mag >= SUM_W'(H_INF_MAG))
            mag_o = H_INF_MAG;
        else if (flush_en && mag < SUM_W'(H_MINNORM))
            mag_o = '0;
        else
            mag_o = mag[MAG_W-1:0];
        if (e == '1)
            mag_o = (m != '0) ? {{F16_EW{1'b1}}, 1'b1, m[F32_MW-2 -: F16_MW-1]} : H_INF_MAG;
        h = {s, mag_o};
    end
endmodule

// File: rtl/f2h_clamp.sv
// f2h_clamp: optional saturation of a half value to [0.0, 1.0]. NaN and any
// value with the sign bit set go to +0.0; anything above 1.0 goes to 1.0.
module f2h_clamp
    import f2h_pkg::*;
(
    input  logic [F16_W-1:0] h_in,
    input  logic             clamp_en,
    output logic [F16_W-1:0] h_out
);
    logic is_nan;

    // Select the clamped or unmodified half value.
    always_comb begin
        is_nan = (h_in[MAG_W-1:F16_MW] == '1) && (h_in[F16_MW-1:0] != '0);
        h_out  = h_in;
        if (clamp_en) begin
            if (is_nan || h_in[F16_W-1])
                h_out = '0;
            else if (h_in[MAG_W-1:0] > H_ONE_MAG)
                h_out = {1'b0, H_ONE_MAG};
        end
    end
endmodule

// File: rtl/f2h_cvt.sv
// f2h_cvt: top of the single-to-half converter. Source modifiers, narrowing
// and clamp are combinational; result and valid are registered once.
// Assumes a synchronous active-low reset.
module f2h_cvt
    import f2h_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      src,
    input  logic             abs_en,
    input  logic             neg_en,
    input  logic [1:0]       rnd_mode,
    input  logic             flush_en,
    input  logic             clamp_en,
    output logic             out_valid,
    output logic [15:0]      result
);
    logic [F32_W-1:0] mod_src;
    logic [F16_W-1:0] narrowed;
    logic [F16_W-1:0] clamped;

    f2h_srcmod u_srcmod (
        .src      (src),
        .abs_en   (abs_en),
        .neg_en   (neg_en),
        .mod_src  (mod_src)
    );

    f2h_narrow u_narrow (
        .x        (mod_src),
        .mode     (rnd_mode_e'(rnd_mode)),
        .flush_en (flush_en),
        .h        (narrowed)
    );

    f2h_clamp u_clamp (
        .h_in     (narrowed),
        .clamp_en (clamp_en),
        .h_out    (clamped)
    );

    // Capture a new result on in_valid; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= clamped;
        end
    end
endmodule

// File: rtl/f2h_cvt_chk.sv
// f2h_cvt_chk: port-level properties of the converter, bound into f2h_cvt.
module f2h_cvt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] src,
    input logic        abs_en,
    input logic        neg_en,
    input logic        flush_en,
    input logic        clamp_en,
    input logic        out_valid,
    input logic [15:0] result
);
    assert_reset_R2: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == 16'h0000));

    assert_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_neg_abs_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && abs_en && neg_en && !clamp_en) |=> result[15]);

    assert_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clamp_en && src[30:23] >= 8'd143 && src[30:23] != 8'hFF)
        |=> result[14:0] == 15'h7C00);

    assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flush_en) |=> !(result[14:10] == 5'd0 && result[9:0] != 10'd0));

    assert_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clamp_en && src[30:23] == 8'hFF && src[22:0] != 23'd0)
        |=> result[14:9] == 6'h3F);

    assert_clamp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && clamp_en) |=> result <= 16'h3C00);
endmodule

bind f2h_cvt f2h_cvt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .src       (src),
    .abs_en    (abs_en),
    .neg_en    (neg_en),
    .flush_en  (flush_en),
    .clamp_en  (clamp_en),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_f2h_cvt.sv
`timescale 1ns/1ps
// tb_f2h_cvt: sweeps exponents and rounding-sensitive fractions in every
// mode against an exact fixed-point model, then adds directed and random cases.
module tb_f2h_cvt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] src = '0;
    logic        abs_en = 1'b0, neg_en = 1'b0, flush_en = 1'b0, clamp_en = 1'b0;
    logic [1:0]  rnd_mode = 2'd0;
    logic        out_valid;
    logic [15:0] result;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    f2h_cvt dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
        .abs_en(abs_en), .neg_en(neg_en), .rnd_mode(rnd_mode),
        .flush_en(flush_en), .clamp_en(clamp_en),
        .out_valid(out_valid), .result(result)
    );

    // Exact model: value held as an integer in units of 2^-149.
    function automatic logic [15:0] ref_conv(input logic [31:0] v, input logic a,
            input logic n, input logic [1:0] md, input logic fl, input logic cl);
        logic sg; logic [7:0] ex; logic [22:0] mt;
        logic [191:0] xv, rem, halfu;
        logic [63:0] nu, ulp, lo, u;
        logic [14:0] mg; logic [15:0] r; logic up; int k;
        sg = a ? n : (v[31] ^ n);
        ex = v[30:23]; mt = v[22:0];
        if (ex == 8'hFF)
            r = (mt != 0) ? {sg, 5'h1F, 1'b1, mt[21:13]} : {sg, 15'h7C00};
        else if (ex >= 8'd143)
            r = {sg, 15'h7C00};
        else begin
            if (ex == 0) xv = {169'b0, mt};
            else         xv = {168'b0, 1'b1, mt} << (ex - 8'd1);
            nu = 64'(xv >> 125);
            k = 0;
            for (int i = 0; i < 64; i++) if (nu[i]) k = i;
            ulp   = (k <= 10) ? 64'd1 : (64'd1 << (k - 10));
            lo    = nu - (nu % ulp);
            rem   = xv - ({128'b0, lo} << 125);
            halfu = {128'b0, ulp} << 124;
            case (md)
                2'd0: up = (rem > halfu) || (rem == halfu && (((lo / ulp) & 64'd1) != 0));
                2'd1: up = !sg && (rem != 0);
                2'd2: up = sg && (rem != 0);
                default: up = 1'b0;
            endcase
            u = lo + (up ? ulp : 64'd0);
            if (u > (64'd65504 << 24)) mg = 15'h7C00;
            else if (u < 64'd1024) mg = (fl && u != 0) ? 15'h0 : u[14:0];
            else begin
                k = 0;
                for (int i = 0; i < 64; i++) if (u[i]) k = i;
                mg = {5'(k - 9), 10'((u >> (k - 10)) & 64'h3FF)};
            end
            r = {sg, mg};
        end
        if (cl) begin
            if ((r[14:10] == 5'h1F && r[9:0] != 0) || r[15]) r = 16'h0000;
            else if (r[14:0] > 15'h3C00) r = 16'h3C00;
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [31:0] v, input logic cl,
            input logic fl, input logic [15:0] ex);
        if (cl) return "R10";
        if (v[30:23] == 8'hFF) return "R9";
        if (v[30:23] == 8'h00) return "R8";
        if (ex[14:0] == 15'h7C00) return "R5";
        if (fl && ex[14:10] == 0) return "R7";
        if (ex[14:10] == 0) return "R6";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h src=%h mode=%0d flush=%0b clamp=%0b abs=%0b neg=%0b",
                     tag, act, exp, src, rnd_mode, flush_en, clamp_en, abs_en, neg_en);
        end
    endtask

    // Drive one operand at the current negedge, check it at the next one.
    task automatic op(input logic [31:0] v, input logic a, input logic n,
            input logic [1:0] md, input logic fl, input logic cl, input logic [15:0] exp,
            input string tag);
        src = v; abs_en = a; neg_en = n; rnd_mode = md; flush_en = fl; clamp_en = cl;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1", {15'b0, out_valid}, 16'h0001);
        check(tag, result, exp);
    endtask

    task automatic op_ref(input logic [31:0] v, input logic a, input logic n,
            input logic [1:0] md, input logic fl, input logic cl);
        logic [15:0] ex;
        ex = ref_conv(v, a, n, md, fl, cl);
        op(v, a, n, md, fl, cl, ex, tag_of(v, cl, fl, ex));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [9:0]  heads [4];
        logic [12:0] tails [6];
        logic [15:0] held;
        heads = '{10'h000, 10'h001, 10'h200, 10'h3FF};
        tails = '{13'h0000, 13'h0001, 13'h0FFF, 13'h1000, 13'h1001, 13'h1FFF};

        // R2: reset values
        repeat (3) @(negedge clk);
        check("R2", {15'b0, out_valid}, 16'h0000);
        check("R2", result, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed cases with hand-computed results
        op(32'h3F800000, 1, 1, 2'd0, 0, 0, 16'hBC00, "R3");
        op(32'hBF800000, 1, 0, 2'd0, 0, 0, 16'h3C00, "R3");
        op(32'hBF800000, 0, 1, 2'd0, 0, 0, 16'h3C00, "R3");
        op(32'h3F800000, 0, 1, 2'd0, 0, 0, 16'hBC00, "R3");
        op(32'h3FAAA000, 0, 0, 2'd0, 0, 0, 16'h3D55, "R4");
        op(32'h3FAAB000, 0, 0, 2'd0, 0, 0, 16'h3D56, "R4");
        op(32'h3FAAA001, 0, 0, 2'd1, 0, 0, 16'h3D56, "R4");
        op(32'hBFAAA001, 0, 0, 2'd2, 0, 0, 16'hBD56, "R4");
        op(32'hBFAAA001, 0, 0, 2'd3, 0, 0, 16'hBD55, "R4");
        op(32'h477FF000, 0, 0, 2'd0, 0, 0, 16'h7C00, "R5");
        op(32'h477FF000, 0, 0, 2'd3, 0, 0, 16'h7BFF, "R5");
        op(32'h477FEFFF, 0, 0, 2'd0, 0, 0, 16'h7BFF, "R5");
        op(32'h47800000, 0, 0, 2'd2, 0, 0, 16'h7C00, "R5");
        op(32'hC7800000, 0, 0, 2'd1, 0, 0, 16'hFC00, "R5");
        op(32'h33800000, 0, 0, 2'd0, 0, 0, 16'h0001, "R6");
        op(32'h387FE000, 0, 0, 2'd0, 0, 0, 16'h0400, "R6");
        op(32'h33800000, 0, 0, 2'd0, 1, 0, 16'h0000, "R7");
        op(32'hB3800000, 0, 0, 2'd0, 1, 0, 16'h8000, "R7");
        op(32'h00000001, 0, 0, 2'd1, 0, 0, 16'h0001, "R8");
        op(32'h00000001, 0, 0, 2'd1, 1, 0, 16'h0000, "R8");
        op(32'h80000001, 0, 0, 2'd2, 0, 0, 16'h8001, "R8");
        op(32'h00400000, 0, 0, 2'd0, 0, 0, 16'h0000, "R8");
        op(32'h7FC00000, 0, 0, 2'd0, 0, 0, 16'h7E00, "R9");
        op(32'h7F800001, 0, 0, 2'd0, 0, 0, 16'h7E00, "R9");
        op(32'hFF800000, 0, 0, 2'd0, 0, 0, 16'hFC00, "R9");
        op(32'h40000000, 0, 0, 2'd0, 0, 1, 16'h3C00, "R10");
        op(32'hBF800000, 0, 0, 2'd0, 0, 1, 16'h0000, "R10");
        op(32'h7FC00000, 0, 0, 2'd0, 0, 1, 16'h0000, "R10");
        op(32'h3F000000, 0, 0, 2'd0, 0, 1, 16'h3800, "R10");
        op(32'h80000000, 0, 0, 2'd0, 0, 1, 16'h0000, "R10");

        // R1: result held and out_valid low while in_valid is low
        held = result;
        in_valid = 1'b0; src = 32'h40490FDB;
        @(negedge clk);
        check("R1", {15'b0, out_valid}, 16'h0000);
        check("R1", result, held);
        @(negedge clk);
        check("R1", result, held);

        // Sweep: exponents x rounding-sensitive fractions x modes x flush x sign
        for (int ei = 0; ei < 55; ei++) begin
            logic [7:0] ex;
            ex = (ei < 51) ? 8'(95 + ei) : (ei == 51 ? 8'd0 : ei == 52 ? 8'd1 : ei == 53 ? 8'd254 : 8'd255);
            for (int hi = 0; hi < 4; hi++)
                for (int ti = 0; ti < 6; ti++)
                    for (int md = 0; md < 4; md++)
                        for (int fl = 0; fl < 2; fl++)
                            for (int sg = 0; sg < 2; sg++)
                                op_ref({sg[0], ex, heads[hi], tails[ti]}, 0, 0, md[1:0], fl[0], 0);
        end

        // Random operands with random modifiers and clamp
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] v;
            logic [5:0]  knobs;
            v = $urandom;
            if (i % 2 == 0) v[30:23] = 8'(100 + $urandom_range(0, 45));
            knobs = 6'($urandom);
            op_ref(v, knobs[0], knobs[1], knobs[3:2], knobs[4], knobs[5] & (i % 3 == 0));
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule